// File: doc/BRIEF.md
# Four-Lane Packet Framing Token Builder

This transmit-side block sits between the link layer and the per-lane scramblers of a four-lane serial link that uses block-based scrambled encoding. For every transaction packet it first emits a four-byte start token. The token carries a start code, the total packet length in doublewords, a short CRC and a parity bit that protect that length, and the link-layer sequence number. It then passes the packet body through as one doubleword per cycle, with one byte on each lane. When no token and no body doubleword is due, every lane carries the one-symbol idle token.

The upstream side offers a packet by raising `in_valid` together with `in_sop`, and presents the body length in doublewords and the sequence number in the same cycle. The block spends that cycle building the token and keeps `in_ready` low. It then raises `in_ready` until it has accepted exactly the announced number of body doublewords (header, data and link CRC). A free-running symbol counter marks the first symbol of every scrambler block. Packets are never aligned to blocks, so a token can land anywhere in a block and a body can run across several blocks.

Top module: `pkt_frame_tok`

## Requirements
- R1: While reset is held, every lane shows 00h, `out_tok` and `out_blk_first` are low, and `in_ready` is low.
- R2: When `in_valid` and `in_sop` are high in a cycle where `in_ready` is low, the next output symbol is a token: `out_tok` is high for that one symbol, and lane 0 bits 3..0 hold the start code Fh.
- R3: The token length field equals `in_len` + 1 (body plus the token doubleword). Lane 0 bits 7,6,5,4 hold length bits 7,8,9,10, and lane 1 bits 6 down to 0 hold length bits 0 up to 6.
- R4: The token carries a 4-bit CRC of the length, with generator x^4+x+1, initial value 0, and length bits fed from bit 10 down to bit 0. CRC bit 3 sits in lane 1 bit 7, and CRC bits 0,1,2 sit in lane 2 bits 2,1,0.
- R5: Lane 2 bit 3 is a parity bit that makes the 11 length bits, the 4 CRC bits and the parity bit together hold an even number of ones.
- R6: Sequence bits 11..8 sit in lane 2 bits 7..4, and sequence bits 7..0 form lane 3.
- R7: After a token, `in_ready` stays high until `in_len` doublewords have been accepted. Each accepted doubleword appears on the output in the following cycle, with input byte k (bits 8k+7..8k) on lane k.
- R8: A cycle that emits neither a token nor a body doubleword puts 00h on all four lanes. This covers `in_valid` without `in_sop` while no packet is open, and a gap in `in_valid` inside a packet body.
- R9: A packet offered in the cycle right after the last body doubleword has its token emitted in the next symbol, with no idle symbol between. `in_sop` raised during a body is carried as ordinary data.
- R10: `out_blk_first` is high on output symbols 0, 16, 32, ... counted from the first clock edge after reset. It does not depend on where packets start or end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a start request or a body doubleword |
| in_sop | input | 1 | With in_valid while no packet is open: request a new packet |
| in_len | input | 11 | Body length in doublewords (1..2046), sampled with the start request |
| in_seq | input | 12 | Sequence number, sampled with the start request |
| in_dw | input | 32 | Body doubleword, byte k goes to lane k |
| in_ready | output | 1 | High while the block accepts body doublewords |
| out_sym | output | 32 | One symbol per lane, lane k at bits 8k+7..8k |
| out_tok | output | 1 | Current symbol is a start token |
| out_blk_first | output | 1 | Current symbol is the first of a scrambler block |

## Verification
On every cycle the assertions check that a token carries the start code, that its length, CRC and parity bits hold even parity, that a token is always followed by an open body with `in_ready` high, that the body countdown never sits at zero while a body is open, and that block-start marks never occur on two consecutive symbols. The exact bit placement of the length, CRC and sequence fields can only be shown by the bench scenarios. The same holds for the doubleword count per packet, back-to-back tokens, idle fill during gaps and the alignment of block marks against packets that straddle blocks. The bench compares these against fields it computes itself.

// File: rtl/tokfrm_pkg.sv
package tokfrm_pkg;

   typedef enum logic {
      FRM_IDLE = 1'b0,
      FRM_BODY = 1'b1
   } frm_state_e;

endpackage

// File: rtl/tokfrm_len_crc.sv
module tokfrm_len_crc #(
   parameter int               LEN_W = 11,
   parameter int               CRC_W = 4,
   parameter logic [CRC_W-1:0] POLY  = 4'h3
) (
   input  logic [LEN_W-1:0] len,
   output logic [CRC_W-1:0] crc
);

   logic [CRC_W-1:0] acc;
   logic             fb;

   // serial CRC unrolled over the length bits, most significant bit first
   always_comb begin
      acc = '0;
      fb  = 1'b0;
      for (int i = LEN_W - 1; i >= 0; i--) begin
         fb  = acc[CRC_W-1] ^ len[i];
         acc = {acc[CRC_W-2:0], 1'b0};
         if (fb) acc = acc ^ POLY;
      end
      crc = acc;
   end

endmodule

// File: rtl/tokfrm_pack.sv
module tokfrm_pack #(
   parameter int LEN_W   = 11,
   parameter int SEQ_W   = 12,
   parameter int CRC_W   = 4,
   parameter int START_W = 4,
   parameter int BUS_W   = 32
) (
   input  logic [LEN_W-1:0]   len,
   input  logic [CRC_W-1:0]   crc,
   input  logic [SEQ_W-1:0]   seq,
   input  logic [START_W-1:0] start,
   output logic [BUS_W-1:0]   tok
);

   logic par;

   assign par = ^{len, crc};

   // lane 0: bits 3..0 start code, bits 7..4 carry length bits 7..10
   // lane 1: bit 7 crc[3], bits 6..0 carry length bits 0..6
   // lane 2: bits 7..4 seq[11:8], bit 3 parity, bits 2..0 carry crc bits 0..2
   // lane 3: seq[7:0]
   always_comb begin
      tok = '0;
      tok[START_W-1:0] = start;
      for (int j = 0; j < 4; j++) tok[7 - j] = len[7 + j];
      tok[15] = crc[3];
      for (int j = 0; j < 7; j++) tok[14 - j] = len[j];
      tok[23:20] = seq[11:8];
      tok[19]    = par;
      for (int j = 0; j < 3; j++) tok[18 - j] = crc[j];
      tok[31:24] = seq[7:0];
   end

endmodule

// File: rtl/tokfrm_blkpos.sv
module tokfrm_blkpos #(
   parameter int BLOCK_SYMS = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic first
);

   localparam int               CNT_W = (BLOCK_SYMS > 2) ? $clog2(BLOCK_SYMS) : 1;
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(BLOCK_SYMS - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         first <= 1'b0;
      end else begin
         first <= (cnt == '0);
         cnt   <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
      end
   end

   assert_first_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      first |=> !first);

endmodule

// File: rtl/pkt_frame_tok.sv
module pkt_frame_tok
   import tokfrm_pkg::*;
#(
   parameter int                 LANES      = 4,
   parameter int                 SYM_W      = 8,
   parameter int                 LEN_W      = 11,
   parameter int                 SEQ_W      = 12,
   parameter int                 CRC_W      = 4,
   parameter logic [CRC_W-1:0]   CRC_POLY   = 4'h3,
   parameter int                 START_W    = 4,
   parameter logic [START_W-1:0] START_CODE = 4'hF,
   parameter logic [SYM_W-1:0]   IDLE_SYM   = 8'h00,
   parameter int                 BLOCK_SYMS = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_sop,
   input  logic [LEN_W-1:0]       in_len,
   input  logic [SEQ_W-1:0]       in_seq,
   input  logic [LANES*SYM_W-1:0] in_dw,
   output logic                   in_ready,
   output logic [LANES*SYM_W-1:0] out_sym,
   output logic                   out_tok,
   output logic                   out_blk_first
);

   localparam int                 BUS_W    = LANES * SYM_W;
   localparam logic [BUS_W-1:0]   IDLE_BUS = {LANES{IDLE_SYM}};

   // the token layout is tied to four byte lanes and fixed field widths
   if (LANES != 4 || SYM_W != 8 || LEN_W != 11 || SEQ_W != 12 ||
       CRC_W != 4 || START_W != 4) begin : g_bad_layout
      $error("pkt_frame_tok: token layout needs 4 lanes of 8 bits and 11/12/4/4-bit fields");
   end
   if (BLOCK_SYMS < 2) begin : g_bad_block
      $error("pkt_frame_tok: BLOCK_SYMS must be at least 2");
   end

   frm_state_e       st;
   logic [LEN_W-1:0] rem;
   logic [LEN_W-1:0] tok_len;
   logic [CRC_W-1:0] tok_crc;
   logic [BUS_W-1:0] tok_bus;
   logic             launch;
   logic             take;

   assign in_ready = (st == FRM_BODY);
   assign launch   = (st == FRM_IDLE) && in_valid && in_sop;
   assign take     = in_ready && in_valid;
   assign tok_len  = in_len + LEN_W'(1);

   tokfrm_len_crc #(
      .LEN_W (LEN_W),
      .CRC_W (CRC_W),
      .POLY  (CRC_POLY)
   ) u_crc (
      .len (tok_len),
      .crc (tok_crc)
   );

   tokfrm_pack #(
      .LEN_W   (LEN_W),
      .SEQ_W   (SEQ_W),
      .CRC_W   (CRC_W),
      .START_W (START_W),
      .BUS_W   (BUS_W)
   ) u_pack (
      .len   (tok_len),
      .crc   (tok_crc),
      .seq   (in_seq),
      .start (START_CODE),
      .tok   (tok_bus)
   );

   tokfrm_blkpos #(
      .BLOCK_SYMS (BLOCK_SYMS)
   ) u_blkpos (
      .clk   (clk),
      .rst_n (rst_n),
      .first (out_blk_first)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= FRM_IDLE;
         rem     <= '0;
         out_sym <= IDLE_BUS;
         out_tok <= 1'b0;
      end else begin
         out_tok <= launch;
         if (launch) begin
            out_sym <= tok_bus;
            rem     <= in_len;
            st      <= FRM_BODY;
         end else if (take) begin
            out_sym <= in_dw;
            rem     <= rem - LEN_W'(1);
            if (rem == LEN_W'(1)) st <= FRM_IDLE;
         end else begin
            out_sym <= IDLE_BUS;
         end
      end
   end

   assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (in_len != '0));

   assert_tok_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_tok |-> (out_sym[START_W-1:0] == START_CODE));

   assert_tok_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_tok |-> ((^out_sym[7:4] ^ ^out_sym[15:8] ^ ^out_sym[19:16]) == 1'b0));

   assert_tok_opens_body_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_tok |-> in_ready);

   assert_tok_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_tok |=> !out_tok);

   assert_body_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (rem != '0));

endmodule

// File: tb/tb_pkt_frame_tok.sv
module tb_pkt_frame_tok;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic [10:0] in_len = '0;
   logic [11:0] in_seq = '0;
   logic [31:0] in_dw = '0;
   logic        in_ready;
   logic [31:0] out_sym;
   logic        out_tok;
   logic        out_blk_first;

   int checks = 0;
   int fails  = 0;

   // bench model of the expected stream
   bit          m_body = 1'b0;
   int          m_rem = 0;
   int          sym_idx = 0;
   int          exp_kind = 0;      // 0 idle, 1 token, 2 body
   logic [31:0] exp_dw = '0;
   logic [10:0] exp_len = '0;
   logic [11:0] exp_seq = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_frame_tok dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_sop        (in_sop),
      .in_len        (in_len),
      .in_seq        (in_seq),
      .in_dw         (in_dw),
      .in_ready      (in_ready),
      .out_sym       (out_sym),
      .out_tok       (out_tok),
      .out_blk_first (out_blk_first)
   );

   function automatic logic [3:0] ref_crc(input logic [10:0] l);
      logic [3:0] c = 4'h0;
      for (int i = 10; i >= 0; i--) begin
         logic f = c[3] ^ l[i];
         c = {c[2:0], 1'b0} ^ (f ? 4'b0011 : 4'b0000);
      end
      return c;
   endfunction

   function automatic logic [10:0] get_len(input logic [31:0] b);
      logic [10:0] l;
      for (int j = 0; j < 4; j++) l[7 + j] = b[7 - j];
      for (int j = 0; j < 7; j++) l[j] = b[14 - j];
      return l;
   endfunction

   function automatic logic [3:0] get_crc(input logic [31:0] b);
      logic [3:0] c;
      c[3] = b[15];
      for (int j = 0; j < 3; j++) c[j] = b[18 - j];
      return c;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one cycle of inputs, check ready, advance, check outputs
   task automatic step(input bit v, input bit s, input logic [10:0] l,
                       input logic [11:0] q, input logic [31:0] d);
      in_valid = v; in_sop = s; in_len = l; in_seq = q; in_dw = d;
      #1;
      chk(in_ready == m_body, "R7 in_ready", {31'd0, in_ready}, {31'd0, m_body});
      if (!m_body && v && s) begin
         exp_kind = 1; exp_len = l + 11'd1; exp_seq = q;
         m_body = 1'b1; m_rem = int'(l);
      end else if (m_body && v) begin
         exp_kind = 2; exp_dw = d;
         m_rem--;
         if (m_rem == 0) m_body = 1'b0;
      end else begin
         exp_kind = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk(out_blk_first == ((sym_idx % 16) == 0), "R10 block first",
          {31'd0, out_blk_first}, {31'd0, ((sym_idx % 16) == 0)});
      sym_idx++;
      chk(out_tok == (exp_kind == 1), "R2 out_tok", {31'd0, out_tok}, {31'd0, (exp_kind == 1)});
      if (exp_kind == 1) begin
         logic [3:0] ec = ref_crc(exp_len);
         chk(out_sym[3:0] == 4'hF, "R2 start code", {28'd0, out_sym[3:0]}, 32'hF);
         chk(get_len(out_sym) == exp_len, "R3 length field", {21'd0, get_len(out_sym)}, {21'd0, exp_len});
         chk(get_crc(out_sym) == ec, "R4 length crc", {28'd0, get_crc(out_sym)}, {28'd0, ec});
         chk(out_sym[19] == ^{exp_len, ec}, "R5 parity", {31'd0, out_sym[19]}, {31'd0, ^{exp_len, ec}});
         chk({out_sym[23:20], out_sym[31:24]} == exp_seq, "R6 sequence",
             {20'd0, out_sym[23:20], out_sym[31:24]}, {20'd0, exp_seq});
      end else if (exp_kind == 2) begin
         chk(out_sym == exp_dw, "R7 body striping", out_sym, exp_dw);
      end else begin
         chk(out_sym == 32'h0, "R8 idle fill", out_sym, 32'h0);
      end
   endtask

   // gap_pct: chance of a bubble before each body word; sop_in_body: raise sop on data (R9)
   task automatic send_pkt(input logic [10:0] l, input logic [11:0] q,
                           input int gap_pct, input bit sop_in_body);
      step(1'b1, 1'b1, l, q, $urandom);
      for (int i = 0; i < int'(l); i++) begin
         if (($urandom % 100) < gap_pct) step(1'b0, 1'b0, '0, '0, $urandom);
         step(1'b1, sop_in_body ? 1'($urandom) : 1'b0, 11'($urandom), 12'($urandom), $urandom);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      process::self().srandom(32'd20240611);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(out_sym == 32'h0, "R1 reset lanes", out_sym, 32'h0);
      chk(out_tok == 1'b0, "R1 reset out_tok", {31'd0, out_tok}, 32'd0);
      chk(out_blk_first == 1'b0, "R1 reset block first", {31'd0, out_blk_first}, 32'd0);
      chk(in_ready == 1'b0, "R1 reset in_ready", {31'd0, in_ready}, 32'd0);
      rst_n = 1'b1;

      // R8: valid without sop while no packet is open is ignored
      repeat (3) step(1'b1, 1'b0, 11'd4, 12'h123, 32'hDEADBEEF);
      // worked example: 3-dword header, 1 data, 1 link CRC -> length 6
      send_pkt(11'd5, 12'hABC, 0, 1'b0);
      step(1'b0, 1'b0, '0, '0, '0);
      // R9: back-to-back packets, minimum length, sop inside body carried as data
      send_pkt(11'd1, 12'h001, 0, 1'b0);
      send_pkt(11'd1, 12'hFFF, 0, 1'b0);
      send_pkt(11'd7, 12'h800, 0, 1'b1);
      send_pkt(11'd3, 12'h07F, 0, 1'b0);
      // long packet straddling several blocks, with bubbles (R8, R10)
      send_pkt(11'd40, 12'h555, 20, 1'b0);
      // largest length: field 2047, all length bits set
      send_pkt(11'd2046, 12'hAAA, 0, 1'b0);
      // random mix
      for (int p = 0; p < 80; p++) begin
         int idl = $urandom % 4;
         for (int k = 0; k < idl; k++) step(1'($urandom), 1'b0, '0, '0, $urandom);
         send_pkt(11'(1 + ($urandom % 24)), 12'($urandom), 15, 1'($urandom));
      end
      repeat (20) step(1'b0, 1'b0, '0, '0, '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule